// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard-resolution control for a five-stage, in-order, 32-bit pipeline. The stages are fetch, decode with register read, execute, memory access and writeback. Each cycle it looks at three sets of pipeline-register fields. From decode it takes the source register numbers. From execute it takes the source register numbers, the destination number, the write enable, the load flag and the branch flag. From the memory and writeback stages it takes the destination numbers and write enables. It then decides how the datapath moves on that cycle.

Both ALU operands in execute get a forward select. The select picks the register-file value, the result held in the execute/memory register, or the result held in the memory/writeback register. When a load in execute feeds an instruction in decode, the block holds the PC and the fetch/decode register for one cycle and puts a bubble into the decode/execute register. A branch is handled by stalling. While a branch sits in decode or execute, no new instruction enters decode.

The register file writes in the first half of the cycle and reads in the second half. For that reason there is no forwarding path from writeback into decode. All outputs are combinational in the current pipeline-register contents.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An operand select is 2'b10 when the memory-stage write enable is set, the memory-stage destination is nonzero, and it equals that operand's execute-stage source.
- R2: An operand select is 2'b01 when the writeback-stage write enable is set, the writeback destination is nonzero and equals the source, and R1 does not apply.
- R3: When the memory and writeback stages both match a source under R1 and R2, the select is 2'b10.
- R4: A source of register 0, or a stage whose write enable is clear, never produces a select other than 2'b00 from that stage.
- R5: With no matching producer the select is 2'b00, the register-file value.
- R6: A load-use hazard raises pc_hold_o, ifid_hold_o and idex_bubble_o together. The hazard is an execute-stage load with write enable set and a nonzero destination equal to either decode source.
- R7: An execute-stage producer that is not a load, or whose destination is register 0, never raises ifid_hold_o or idex_bubble_o.
- R8: A branch in decode without a load-use hazard raises pc_hold_o and ifid_bubble_o.
- R9: A branch in execute raises ifid_bubble_o and, without a load-use hazard or a decode branch, leaves pc_hold_o low.
- R10: A load-use hazard takes precedence over branch control: ifid_bubble_o is low whenever ifid_hold_o is high.
- R11: Operand B follows R1 to R5 from the second execute source, independently of operand A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_W | First source register of the instruction in decode |
| id_rs2_i | input | REG_W | Second source register of the instruction in decode |
| id_branch_i | input | 1 | Instruction in decode is a branch |
| ex_rs1_i | input | REG_W | First source register of the instruction in execute |
| ex_rs2_i | input | REG_W | Second source register of the instruction in execute |
| ex_rd_i | input | REG_W | Destination register of the instruction in execute |
| ex_we_i | input | 1 | Register write enable in execute |
| ex_load_i | input | 1 | Instruction in execute is a load |
| ex_branch_i | input | 1 | Instruction in execute is a branch |
| mem_rd_i | input | REG_W | Destination register held in the execute/memory register |
| mem_we_i | input | 1 | Write enable held in the execute/memory register |
| wb_rd_i | input | REG_W | Destination register held in the memory/writeback register |
| wb_we_i | input | 1 | Write enable held in the memory/writeback register |
| fwd_a_o | output | 2 | ALU operand A select: 00 register file, 10 memory stage, 01 writeback stage |
| fwd_b_o | output | 2 | ALU operand B select, same encoding |
| pc_hold_o | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged |
| ifid_bubble_o | output | 1 | Load a bubble into the fetch/decode register |
| idex_bubble_o | output | 1 | Load a bubble (writes and memory enables cleared) into the decode/execute register |

## Verification
The assertions check on every input change that stage priority holds, that register 0 and cleared write enables are never forwarded, that a load-use match raises all three stall outputs, and that a hold and a bubble on the fetch/decode register never occur together. Some properties can only be shown by the bench's exhaustive sweeps over small register numbers. These are the exact select value for every combination of matches across the two stages, the independence of operand B from operand A, and the full branch and load-use interaction table.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);
  logic mem_hit, wb_hit, src_nz;

  assign src_nz  = |src_i;
  assign mem_hit = mem_we_i && src_nz && (mem_rd_i == src_i);
  assign wb_hit  = wb_we_i  && src_nz && (wb_rd_i  == src_i);

  // younger producer wins
  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  output logic             stall_o
);
  logic ld_live;

  assign ld_live = ex_load_i && ex_we_i && (|ex_rd_i);
  assign stall_o = ld_live && ((ex_rd_i == id_rs1_i) || (ex_rd_i == id_rs2_i));
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl (
  input  logic ld_stall_i,
  input  logic id_branch_i,
  input  logic ex_branch_i,
  output logic pc_hold_o,
  output logic ifid_hold_o,
  output logic ifid_bubble_o,
  output logic idex_bubble_o
);
  logic br_pending;

  assign br_pending    = id_branch_i || ex_branch_i;
  // a branch in ex redirects the PC itself, so only a decode branch holds it
  assign pc_hold_o     = ld_stall_i || id_branch_i;
  assign ifid_hold_o   = ld_stall_i;
  assign ifid_bubble_o = !ld_stall_i && br_pending;
  assign idex_bubble_o = ld_stall_i;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_branch_i,
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  input  logic             ex_branch_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             pc_hold_o,
  output logic             ifid_hold_o,
  output logic             ifid_bubble_o,
  output logic             idex_bubble_o
);
  logic [REG_W-1:0] ex_src [NUM_OPS];
  fwd_sel_e         op_sel [NUM_OPS];
  logic             ld_stall;

  assign ex_src[0] = ex_rs1_i;
  assign ex_src[1] = ex_rs2_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_unit #(.REG_W(REG_W)) i_fwd (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (op_sel[g])
    );
  end

  assign fwd_a_o = op_sel[0];
  assign fwd_b_o = op_sel[1];

  hz_load_use #(.REG_W(REG_W)) i_ld (
    .id_rs1_i  (id_rs1_i),
    .id_rs2_i  (id_rs2_i),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .stall_o   (ld_stall)
  );

  hz_branch_ctl i_br (
    .ld_stall_i    (ld_stall),
    .id_branch_i   (id_branch_i),
    .ex_branch_i   (ex_branch_i),
    .pc_hold_o     (pc_hold_o),
    .ifid_hold_o   (ifid_hold_o),
    .ifid_bubble_o (ifid_bubble_o),
    .idex_bubble_o (idex_bubble_o)
  );
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] id_rs1_i,
  input logic [REG_W-1:0] id_rs2_i,
  input logic             id_branch_i,
  input logic [REG_W-1:0] ex_rs1_i,
  input logic [REG_W-1:0] ex_rs2_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_we_i,
  input logic             ex_load_i,
  input logic             ex_branch_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_we_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             wb_we_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             pc_hold_o,
  input logic             ifid_hold_o,
  input logic             ifid_bubble_o,
  input logic             idex_bubble_o
);
  always_comb begin
    if (mem_we_i && (|mem_rd_i) && mem_rd_i == ex_rs1_i)
      a_r3_mem_first_a: assert (fwd_a_o == 2'b10);
    if (mem_we_i && (|mem_rd_i) && mem_rd_i == ex_rs2_i)
      a_r11_mem_first_b: assert (fwd_b_o == 2'b10);
    if (ex_rs1_i == '0)
      a_r4_zero_src_a: assert (fwd_a_o == 2'b00);
    if (!mem_we_i && !wb_we_i)
      a_r4_no_we: assert (fwd_a_o == 2'b00 && fwd_b_o == 2'b00);
    a_r1_legal_code: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11);
    if (ex_load_i && ex_we_i && (|ex_rd_i) && (ex_rd_i == id_rs1_i || ex_rd_i == id_rs2_i))
      a_r6_load_use: assert (pc_hold_o && ifid_hold_o && idex_bubble_o);
    if (!ex_load_i)
      a_r7_no_alu_stall: assert (!ifid_hold_o && !idex_bubble_o);
    a_r10_hold_excl: assert (!(ifid_hold_o && ifid_bubble_o));
    if (id_branch_i)
      a_r8_branch_id: assert (pc_hold_o);
  end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W)) i_chk (.*);

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
  localparam int unsigned W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic         id_br, ex_we, ex_ld, ex_br, mem_we, wb_we;
  logic [1:0]   fa, fb;
  logic         pc_hold, ifid_hold, ifid_bub, idex_bub;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  pipe_hazard_ctrl #(.REG_W(W)) i_pipe_hazard_ctrl (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_branch_i(id_br),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_we_i(ex_we), .ex_load_i(ex_ld), .ex_branch_i(ex_br),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fa), .fwd_b_o(fb), .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .ifid_bubble_o(ifid_bub), .idex_bubble_o(idex_bub)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input int src, input int mrd, input int mwe,
                                         input int wrd, input int wwe);
    if (mwe != 0 && mrd != 0 && mrd == src) return 2'b10;
    if (wwe != 0 && wrd != 0 && wrd == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {id_br, ex_we, ex_ld, ex_br, mem_we, wb_we} = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    chk("R5 idle fwd_a", fa, 0);
    chk("R5 idle fwd_b", fb, 0);
    chk("R7 idle stall", {pc_hold, ifid_hold, ifid_bub, idex_bub}, 0);

    // R1 R2 R3 R4 R5: operand A sweep, operand B driven with a fixed source
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          for (int e = 0; e < 4; e++) begin
            @(posedge clk);
            idle();
            ex_rs1 = 5'(s); ex_rs2 = 5'd7;
            mem_rd = 5'(m); wb_rd = 5'(w);
            mem_we = e[0]; wb_we = e[1];
            @(negedge clk);
            chk("R1/R2/R3/R4/R5 fwd_a", fa, exp_sel(s, m, e & 1, w, e >> 1));
            chk("R11 fwd_b unaffected", fb, 0);
          end

    // R11: operand B sweep with operand A on a differing source
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          for (int e = 0; e < 4; e++) begin
            @(posedge clk);
            idle();
            ex_rs2 = 5'(s); ex_rs1 = 5'd9;
            mem_rd = 5'(m); wb_rd = 5'(w);
            mem_we = e[0]; wb_we = e[1];
            @(negedge clk);
            chk("R11 fwd_b", fb, exp_sel(s, m, e & 1, w, e >> 1));
            chk("R11 fwd_a independent", fa, 0);
          end

    // R6 R7: load-use sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 4; d++)
          for (int f = 0; f < 4; f++) begin
            logic ls;
            @(posedge clk);
            idle();
            id_rs1 = 5'(a); id_rs2 = 5'(b); ex_rd = 5'(d);
            ex_ld = f[0]; ex_we = f[1];
            ls = f[0] && f[1] && d != 0 && (d == a || d == b);
            @(negedge clk);
            chk("R6/R7 pc_hold", pc_hold, ls);
            chk("R6/R7 ifid_hold", ifid_hold, ls);
            chk("R6/R7 idex_bubble", idex_bub, ls);
            chk("R6 ifid_bubble", ifid_bub, 0);
          end

    // R8 R9 R10: branch and load-use interaction
    for (int k = 0; k < 8; k++) begin
      logic ib, eb, lu, ls;
      ib = k[0]; eb = k[1]; lu = k[2];
      if (eb && lu) continue;
      @(posedge clk);
      idle();
      id_br = ib; ex_br = eb;
      id_rs1 = 5'd3; ex_rd = 5'd3; ex_we = 1'b1; ex_ld = lu;
      ls = lu;
      @(negedge clk);
      chk("R8/R9 pc_hold", pc_hold, ls | ib);
      chk("R10 ifid_hold", ifid_hold, ls);
      chk("R8/R9/R10 ifid_bubble", ifid_bub, !ls && (ib || eb));
      chk("R10 idex_bubble", idex_bub, ls);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule